// File: doc/BRIEF.md
# Regulator Power-Up Sequencer

This block takes a switching regulator from shutdown to regulation. It watches three qualified inputs: the bias power-on-reset comparator and two enable comparators. When all three are high, it runs a soft-start in four periods. First comes a fixed settling delay. Next is a ramp to the boot voltage. Then the rail dwells at the boot voltage. Last, the rail ramps to the code that a VID read over the serial bus returns.

Ramps are not generated here. The block passes a target code to an external slew controller through a request/done handshake. The bus read is also external; the block only raises a read request and takes in the result, which is either a valid code or the OFF code.

A boot code of zero means there is no boot voltage. In that case the block stays quiet until the first set command with a non-zero code arrives, then ramps straight to that code without a dwell or a bus read. An OFF result keeps the power stage off. Ready is raised only after the last ramp, and only while output monitoring reports the output inside its regulation window. Losing any of the three inputs in any state returns the block to shutdown.

Top module: `vr_powerup_seq`

## Requirements
- R1: While reset is active, and on the first cycle after it, `pwm_hiz` is 1 and `ramp_req`, `vid_rd_req` and `vr_ready` are 0.
- R2: While any of `por_ok`, `en_a`, `en_b` is low, the block stays in shutdown: `pwm_hiz` stays 1 and no ramp or read request is raised.
- R3: Suppose the three inputs are first sampled all high at clock edge k and the boot code is non-zero. Then `ramp_req` rises at edge k+DLY_CYCLES, and `pwm_hiz` stays 1 until that edge.
- R4: The boot ramp targets `boot_code`, and `pwm_hiz` is 0 from the edge on which that ramp is requested.
- R5: With `boot_code` equal to 0, no ramp is requested after the delay and `pwm_hiz` stays 1. A `set_valid` pulse with a `set_code` of 0 is ignored. The first `set_valid` with a non-zero `set_code` requests a ramp to that code, with no dwell and no VID read.
- R6: Suppose `ramp_done` ends the boot ramp at edge m. Then `vid_rd_req` rises at edge m+DWELL_CYCLES and stays high until `vid_rd_done`.
- R7: A read result with `vid_rd_off`=0 requests a ramp to `vid_rd_code` on the next edge.
- R8: A read result with `vid_rd_off`=1 sets `pwm_hiz` to 1. No ramp is requested, and no further read is requested, until the enables are cycled.
- R9: After the final ramp completes, `vr_ready` follows `in_window` with one register of delay. It is never 1 outside that state, and never 1 together with `pwm_hiz`.
- R10: If any of the three inputs goes low in any state, then on the next edge `pwm_hiz` is 1 and `ramp_req`, `vid_rd_req` and `vr_ready` are 0.
- R11: `ramp_req` stays high with a stable `ramp_target` until `ramp_done` is sampled, and falls on that edge. A ramp request and a read request are never raised together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| por_ok | input | 1 | Bias power-on-reset comparator output, high when bias is good |
| en_a | input | 1 | First enable comparator output |
| en_b | input | 1 | Second enable comparator output |
| boot_code | input | CODE_W | Hard-wired boot voltage code; 0 means no boot voltage |
| set_valid | input | 1 | One-cycle strobe: a set command was received |
| set_code | input | CODE_W | Target code of the set command |
| vid_rd_done | input | 1 | One-cycle strobe: the VID read has finished |
| vid_rd_off | input | 1 | Read result is the OFF code |
| vid_rd_code | input | CODE_W | Code returned by the read |
| ramp_done | input | 1 | Slew controller has reached the requested target |
| in_window | input | 1 | Output voltage is inside the regulation window |
| pwm_hiz | output | 1 | Hold the PWM outputs in high impedance |
| ramp_req | output | 1 | Ramp request to the slew controller |
| ramp_target | output | CODE_W | Target code of the current ramp |
| vid_rd_req | output | 1 | Request a VID read over the bus |
| vr_ready | output | 1 | Regulator ready |

## Verification
The hardest case to reach from the ports is an enable dropping in the middle of a sequence. The drop can land during the delay, during a ramp whose done has not yet arrived, during the dwell, while a read is outstanding, or after regulation has begun. Each case must leave nothing stale that corrupts the next power-up.

The stimulus draws an abort stage at random for each of many power-up runs. It then drives the handshakes up to that stage and drops one randomly chosen input. The next run starts from that aftermath with fresh random boot codes, read results and handshake delays. The zero-boot path and the OFF-code path are mixed into the same random runs, so each is also entered after earlier aborts.

// File: rtl/pwrseq_pkg.sv
// Package: shared state encoding for the regulator power-up sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package pwrseq_pkg;

    typedef enum logic [3:0] {
        ST_SHUTDOWN   = 4'd0,
        ST_DELAY      = 4'd1,
        ST_WAIT_SET   = 4'd2,
        ST_RAMP_BOOT  = 4'd3,
        ST_DWELL      = 4'd4,
        ST_VID_READ   = 4'd5,
        ST_RAMP_FINAL = 4'd6,
        ST_REGULATE   = 4'd7,
        ST_OFF_HOLD   = 4'd8
    } seq_state_e;

    // True for states in which the power stage must stay off.
    function automatic logic state_is_off(seq_state_e s);
        return (s == ST_SHUTDOWN) || (s == ST_DELAY) ||
               (s == ST_WAIT_SET) || (s == ST_OFF_HOLD);
    endfunction

endpackage

// File: rtl/pwrseq_timer.sv
// Module: cycle timer shared by the settling delay and the boot dwell.
// Counts while run is high and flags expiry on the last cycle of the window.
// Assumes: limit >= 1; clr is pulsed on every state change so each window
// starts from zero.
module pwrseq_timer #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          run,
    input  logic [TW-1:0] limit,
    output logic          expired
);

    logic [TW-1:0] cnt_q;

    // Count the cycles spent in a timed window.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt_q <= '0;
        end else if (run) begin
            cnt_q <= cnt_q + TW'(1);
        end
    end

    assign expired = run && (cnt_q == (limit - TW'(1)));

endmodule

// File: rtl/pwrseq_ramp_if.sv
// Module: request/done handshake toward the external slew controller.
// A start strobe latches the target code and raises the request, which is
// held until done is sampled. Abort drops the request at once.
// Assumes: start is never asserted while a request is already pending.
module pwrseq_ramp_if #(
    parameter int CODE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              abort,
    input  logic              start,
    input  logic [CODE_W-1:0] code,
    input  logic              ramp_done,
    output logic              ramp_req,
    output logic [CODE_W-1:0] ramp_target,
    output logic              finished
);

    logic req_q;
    logic [CODE_W-1:0] tgt_q;

    // Hold the request from start until done or abort.
    always_ff @(posedge clk) begin
        if (!rst_n || abort) begin
            req_q <= 1'b0;
        end else if (start) begin
            req_q <= 1'b1;
        end else if (req_q && ramp_done) begin
            req_q <= 1'b0;
        end
    end

    // Latch the target on each new request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tgt_q <= '0;
        end else if (start) begin
            tgt_q <= code;
        end
    end

    assign ramp_req    = req_q;
    assign ramp_target = tgt_q;
    assign finished    = req_q && ramp_done;

endmodule

// File: rtl/pwrseq_fsm.sv
// Module: power-up state machine. It walks the soft-start periods
// delay, boot ramp, dwell and final ramp, plus the zero-boot wait and the
// OFF hold. Any loss of the qualified enable sends it to shutdown.
// Assumes: the timer expiry and the ramp finish come from the sibling
// modules, and all inputs are synchronous to clk.
module pwrseq_fsm #(
    parameter int CODE_W = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   all_en,
    input  logic [CODE_W-1:0]      boot_code,
    input  logic                   set_valid,
    input  logic [CODE_W-1:0]      set_code,
    input  logic                   vid_rd_done,
    input  logic                   vid_rd_off,
    input  logic [CODE_W-1:0]      vid_rd_code,
    input  logic                   ramp_fin,
    input  logic                   tmr_done,
    output pwrseq_pkg::seq_state_e state,
    output logic                   tmr_clr,
    output logic                   tmr_run,
    output logic                   tmr_dwell,
    output logic                   ramp_start,
    output logic [CODE_W-1:0]      ramp_code
);
    import pwrseq_pkg::*;

    seq_state_e state_q, state_d;

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_SHUTDOWN;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state and ramp-start decode.
    always_comb begin
        state_d    = state_q;
        ramp_start = 1'b0;
        ramp_code  = boot_code;
        if (!all_en) begin
            state_d = ST_SHUTDOWN;
        end else begin
            case (state_q)
                ST_SHUTDOWN: state_d = ST_DELAY;
                ST_DELAY: begin
                    if (tmr_done) begin
                        if (boot_code == '0) begin
                            state_d = ST_WAIT_SET;
                        end else begin
                            state_d    = ST_RAMP_BOOT;
                            ramp_start = 1'b1;
                            ramp_code  = boot_code;
                        end
                    end
                end
                ST_WAIT_SET: begin
                    if (set_valid && (set_code != '0)) begin
                        state_d    = ST_RAMP_FINAL;
                        ramp_start = 1'b1;
                        ramp_code  = set_code;
                    end
                end
                ST_RAMP_BOOT: begin
                    if (ramp_fin) state_d = ST_DWELL;
                end
                ST_DWELL: begin
                    if (tmr_done) state_d = ST_VID_READ;
                end
                ST_VID_READ: begin
                    if (vid_rd_done) begin
                        if (vid_rd_off) begin
                            state_d = ST_OFF_HOLD;
                        end else begin
                            state_d    = ST_RAMP_FINAL;
                            ramp_start = 1'b1;
                            ramp_code  = vid_rd_code;
                        end
                    end
                end
                ST_RAMP_FINAL: begin
                    if (ramp_fin) state_d = ST_REGULATE;
                end
                ST_REGULATE: state_d = ST_REGULATE;
                ST_OFF_HOLD: state_d = ST_OFF_HOLD;
                default:     state_d = ST_SHUTDOWN;
            endcase
        end
    end

    // Timer control derived from the current state.
    always_comb begin
        tmr_run   = (state_q == ST_DELAY) || (state_q == ST_DWELL);
        tmr_dwell = (state_q == ST_DWELL);
        tmr_clr   = (state_d != state_q);
    end

    assign state = state_q;

endmodule

// File: rtl/vr_powerup_seq.sv
// Module: top of the regulator power-up sequencer. It qualifies the three
// enable inputs, runs the state machine with a shared timer and a ramp
// handshake, and registers the ready output.
// Assumes: DLY_CYCLES and DWELL_CYCLES are at least 1; comparator inputs are
// already synchronised to clk.
module vr_powerup_seq #(
    parameter int CODE_W       = 8,
    parameter int DLY_CYCLES   = 64,
    parameter int DWELL_CYCLES = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              por_ok,
    input  logic              en_a,
    input  logic              en_b,
    input  logic [CODE_W-1:0] boot_code,
    input  logic              set_valid,
    input  logic [CODE_W-1:0] set_code,
    input  logic              vid_rd_done,
    input  logic              vid_rd_off,
    input  logic [CODE_W-1:0] vid_rd_code,
    input  logic              ramp_done,
    input  logic              in_window,
    output logic              pwm_hiz,
    output logic              ramp_req,
    output logic [CODE_W-1:0] ramp_target,
    output logic              vid_rd_req,
    output logic              vr_ready
);
    import pwrseq_pkg::*;

    localparam int MAX_CYC = (DLY_CYCLES > DWELL_CYCLES) ? DLY_CYCLES : DWELL_CYCLES;
    localparam int TW      = $clog2(MAX_CYC + 1);

    logic              all_en;
    seq_state_e        state;
    logic              tmr_clr, tmr_run, tmr_dwell, tmr_done;
    logic              ramp_start, ramp_fin;
    logic [CODE_W-1:0] ramp_code;
    logic [TW-1:0]     tmr_limit;
    logic              ready_q;

    assign all_en    = por_ok && en_a && en_b;
    assign tmr_limit = tmr_dwell ? TW'(DWELL_CYCLES) : TW'(DLY_CYCLES);

    pwrseq_fsm #(.CODE_W(CODE_W)) i_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .all_en      (all_en),
        .boot_code   (boot_code),
        .set_valid   (set_valid),
        .set_code    (set_code),
        .vid_rd_done (vid_rd_done),
        .vid_rd_off  (vid_rd_off),
        .vid_rd_code (vid_rd_code),
        .ramp_fin    (ramp_fin),
        .tmr_done    (tmr_done),
        .state       (state),
        .tmr_clr     (tmr_clr),
        .tmr_run     (tmr_run),
        .tmr_dwell   (tmr_dwell),
        .ramp_start  (ramp_start),
        .ramp_code   (ramp_code)
    );

    pwrseq_timer #(.TW(TW)) i_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (tmr_clr),
        .run     (tmr_run),
        .limit   (tmr_limit),
        .expired (tmr_done)
    );

    pwrseq_ramp_if #(.CODE_W(CODE_W)) i_ramp (
        .clk         (clk),
        .rst_n       (rst_n),
        .abort       (!all_en),
        .start       (ramp_start),
        .code        (ramp_code),
        .ramp_done   (ramp_done),
        .ramp_req    (ramp_req),
        .ramp_target (ramp_target),
        .finished    (ramp_fin)
    );

    // Ready follows the window flag once regulating.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ready_q <= 1'b0;
        end else begin
            ready_q <= all_en && (state == ST_REGULATE) && in_window;
        end
    end

    assign pwm_hiz    = state_is_off(state);
    assign vid_rd_req = (state == ST_VID_READ);
    assign vr_ready   = ready_q;

endmodule

// File: rtl/pwrseq_checker.sv
// Module: protocol checker for the power-up sequencer, bound to the top.
// Assumes: observes only top-level ports.
module pwrseq_checker #(
    parameter int CODE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              por_ok,
    input logic              en_a,
    input logic              en_b,
    input logic              ramp_done,
    input logic              in_window,
    input logic              pwm_hiz,
    input logic              ramp_req,
    input logic [CODE_W-1:0] ramp_target,
    input logic              vid_rd_req,
    input logic              vr_ready
);

    AST_ENABLE_LOSS_SHUTS: assert property (@(posedge clk) disable iff (!rst_n)
        !(por_ok && en_a && en_b) |=> (pwm_hiz && !ramp_req && !vid_rd_req && !vr_ready)); // R10

    AST_READY_NEEDS_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vr_ready) |-> $past(in_window)); // R9

    AST_NO_READY_WHILE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        vr_ready |-> !pwm_hiz); // R9

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (ramp_req && !ramp_done && por_ok && en_a && en_b) |=> ramp_req); // R11

    AST_TARGET_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (ramp_req && !ramp_done) |=> $stable(ramp_target)); // R11

    AST_REQ_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(ramp_req && vid_rd_req)); // R11

    AST_DONE_DROPS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (ramp_req && ramp_done) |=> !ramp_req); // R11

    AST_RAMP_NOT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        ramp_req |-> !pwm_hiz); // R4

endmodule

bind vr_powerup_seq pwrseq_checker #(.CODE_W(CODE_W)) i_pwrseq_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .por_ok      (por_ok),
    .en_a        (en_a),
    .en_b        (en_b),
    .ramp_done   (ramp_done),
    .in_window   (in_window),
    .pwm_hiz     (pwm_hiz),
    .ramp_req    (ramp_req),
    .ramp_target (ramp_target),
    .vid_rd_req  (vid_rd_req),
    .vr_ready    (vr_ready)
);

// File: tb/test_vr_powerup_seq.sv
module test_vr_powerup_seq;

    localparam int CW    = 8;
    localparam int DLY   = 6;
    localparam int DWELL = 5;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          por_ok, en_a, en_b;
    logic [CW-1:0] boot_code, set_code, vid_rd_code;
    logic          set_valid, vid_rd_done, vid_rd_off, ramp_done, in_window;
    logic          pwm_hiz, ramp_req, vid_rd_req, vr_ready;
    logic [CW-1:0] ramp_target;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    vr_powerup_seq #(.CODE_W(CW), .DLY_CYCLES(DLY), .DWELL_CYCLES(DWELL)) i_vr_powerup_seq (
        .clk(clk), .rst_n(rst_n), .por_ok(por_ok), .en_a(en_a), .en_b(en_b),
        .boot_code(boot_code), .set_valid(set_valid), .set_code(set_code),
        .vid_rd_done(vid_rd_done), .vid_rd_off(vid_rd_off), .vid_rd_code(vid_rd_code),
        .ramp_done(ramp_done), .in_window(in_window), .pwm_hiz(pwm_hiz),
        .ramp_req(ramp_req), .ramp_target(ramp_target), .vid_rd_req(vid_rd_req),
        .vr_ready(vr_ready)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Expected idle/shutdown pattern packed as {hiz, ramp_req, rd_req, ready}.
    function automatic int off_pattern();
        return 8;
    endfunction

    function automatic int out_pattern();
        return {28'd0, pwm_hiz, ramp_req, vid_rd_req, vr_ready};
    endfunction

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic idle_inputs();
        set_valid = 0; set_code = 0; vid_rd_done = 0; vid_rd_off = 0;
        vid_rd_code = 0; ramp_done = 0; in_window = 0;
    endtask

    // Drop one enable at random and check the shutdown pattern next edge.
    task automatic do_abort();
        int which = $urandom_range(0, 2);
        if (which == 0) por_ok = 0; else if (which == 1) en_a = 0; else en_b = 0;
        step(1);
        chk("R10 abort outputs", out_pattern(), off_pattern());
        por_ok = 0; en_a = 0; en_b = 0;
        idle_inputs();
        step(1);
    endtask

    // One power-up run. Abort stages: 1 delay, 2 boot ramp / set wait,
    // 3 dwell, 4 read pending, 5 final ramp, 6 regulating.
    task automatic run_flow(input int boot, input bit off, input int vcode, input int abort_at);
        int cnt;
        idle_inputs();
        boot_code = CW'(boot);
        chk("R2 start in shutdown", out_pattern(), off_pattern());
        por_ok = 1; en_a = 1; en_b = 1;
        if (abort_at == 1) begin step(2); do_abort(); return; end
        if (boot != 0) begin
            cnt = 0;
            do begin
                step(1); cnt++;
                if (!ramp_req) chk("R3 hiz during delay", int'(pwm_hiz), 1);
            end while (!ramp_req && cnt < 50);
            chk("R3 delay length", cnt, DLY + 1);
            chk("R4 boot target", int'(ramp_target), boot);
            chk("R4 stage enabled", int'(pwm_hiz), 0);
            step($urandom_range(0, 3));
            chk("R11 request held", int'(ramp_req), 1);
            if (abort_at == 2) begin do_abort(); return; end
            ramp_done = 1; step(1); ramp_done = 0;
            chk("R11 request drops on done", int'(ramp_req), 0);
            if (abort_at == 3) begin do_abort(); return; end
            cnt = 1;
            while (!vid_rd_req && cnt < 50) begin step(1); cnt++; end
            chk("R6 dwell length", cnt, DWELL + 1);
            step(2);
            chk("R6 read held", int'(vid_rd_req), 1);
            if (abort_at == 4) begin do_abort(); return; end
            vid_rd_done = 1; vid_rd_off = off; vid_rd_code = CW'(vcode);
            step(1);
            vid_rd_done = 0; vid_rd_off = 0;
            if (off) begin
                chk("R8 off code stays off", out_pattern(), off_pattern());
                step(5);
                chk("R8 off code held", out_pattern(), off_pattern());
                por_ok = 0; en_a = 0; en_b = 0; step(1);
                return;
            end
            chk("R7 final ramp req", int'(ramp_req), 1);
            chk("R7 final target", int'(ramp_target), vcode);
        end else begin
            step(DLY + 3);
            chk("R5 no ramp without boot", out_pattern(), off_pattern());
            set_valid = 1; set_code = 0; step(1); set_valid = 0; step(1);
            chk("R5 zero set ignored", out_pattern(), off_pattern());
            if (abort_at == 2) begin do_abort(); return; end
            set_valid = 1; set_code = CW'(vcode); step(1); set_valid = 0;
            chk("R5 set ramp req", int'(ramp_req), 1);
            chk("R5 set target", int'(ramp_target), vcode);
        end
        if (abort_at == 5) begin do_abort(); return; end
        ramp_done = 1; step(1); ramp_done = 0;
        chk("R11 final done drops req", int'(ramp_req), 0);
        chk("R5 no read after ramp", int'(vid_rd_req), 0);
        step(2);
        chk("R9 no ready out of window", int'(vr_ready), 0);
        in_window = 1; step(1);
        chk("R9 ready in window", int'(vr_ready), 1);
        if (abort_at == 6) begin do_abort(); return; end
        in_window = 0; step(1);
        chk("R9 ready follows window", int'(vr_ready), 0);
        in_window = 1; step(1);
        chk("R9 ready returns", int'(vr_ready), 1);
        por_ok = 0; en_a = 0; en_b = 0; step(1);
        chk("R10 enable loss from regulate", out_pattern(), off_pattern());
        idle_inputs();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        rst_n = 0; por_ok = 1; en_a = 1; en_b = 1; boot_code = 8'h40;
        idle_inputs();
        step(3);
        chk("R1 outputs in reset", out_pattern(), off_pattern());
        por_ok = 0; en_a = 0; en_b = 0;
        rst_n = 1; step(1);
        chk("R1 outputs after reset", out_pattern(), off_pattern());
        // R2: every combination with one input low holds shutdown.
        for (int m = 0; m < 3; m++) begin
            por_ok = (m != 0); en_a = (m != 1); en_b = (m != 2);
            step(20);
            chk("R2 partial enable held off", out_pattern(), off_pattern());
        end
        por_ok = 0; en_a = 0; en_b = 0; step(1);
        // Directed corners.
        run_flow(8'h55, 0, 8'h7A, 0);
        run_flow(8'h30, 1, 8'h00, 0);
        run_flow(0, 0, 8'h21, 0);
        run_flow(8'hFF, 0, 8'h01, 0);
        for (int a = 1; a <= 6; a++) run_flow(8'h44, 0, 8'h66, a);
        // Random runs.
        for (int it = 0; it < 40; it++) begin
            int b  = ($urandom_range(0, 3) == 0) ? 0 : $urandom_range(1, 255);
            bit o  = ($urandom_range(0, 4) == 0);
            int v  = $urandom_range(1, 255);
            int ab = $urandom_range(0, 8);
            run_flow(b, o, v, (ab > 6) ? 0 : ab);
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule